// File: doc/BRIEF.md
# Instruction Fetch Sequencer

This block sequences instruction fetch for a small microcontroller core built as a two-stage pipeline. While one instruction is decoded and executed, the block fetches the next one. It holds three pieces of state: a 21-bit program counter, a 16-entry return-address stack, and a 16-bit instruction register.

An external decoder drives the block every cycle with three commands: how to form the next program counter, what to do with the return stack, and whether to keep or cancel the word just fetched. The decoder also supplies the branch fields of the current instruction. The program memory returns the word at `prog_addr` in the same cycle through `prog_data`. That word becomes the current instruction one cycle later.

A subroutine call is a branch command and a push command issued together. A return is the restore command and a pop command issued together. Any misuse of the stack raises an error flag, and that flag stays set until reset.

Top module: `fetch_sequencer`

## Requirements
- R1: In the cycle after a clock edge with `rst_n` low (synchronous reset), `prog_addr` is 0, `instr` is 0 (a NOP) and `stk_err` is 0, and the return stack is empty.
- R2: When `pc_op` is 0 (step), the next `prog_addr` is the current value plus 1, wrapping from 0x1FFFFF to 0.
- R3: When `pc_op` is 1 or 2, the next `prog_addr` is the current value plus the sign-extended `off8` (code 1) or the sign-extended `off11` (code 2), taken modulo 2^21.
- R4: When `pc_op` is 3, the next `prog_addr` equals `abs_target`.
- R5: When `pc_op` is 5 (hold), `prog_addr` keeps its value. Codes 6 and 7 force it to 0x08 and 0x18, respectively.
- R6: When `pc_op` is 4 (restore), the next `prog_addr` is the top stack entry as it stood before that edge, or 0 if the stack is empty.
- R7: When `stk_op` is 1 (push), the pointer is incremented and the current `prog_addr` is written into the new top entry. When `stk_op` is 2 (pop), the top entry stays readable for that cycle and the pointer is decremented at the edge. Codes 0 and 3 leave the stack alone. Entries come back in last-in, first-out order.
- R8: The stack holds 16 entries. A push while 16 entries are held, or a pop while the stack is empty, sets `stk_err`. Neither operation changes the stack contents or the pointer, and `stk_err` stays at 1 until reset.
- R9: When `ir_flush` is 0, `instr` after an edge equals the `prog_data` presented before that edge.
- R10: When `ir_flush` is 1, `instr` after the edge is 0, so the fetched word is dropped and a NOP executes in its place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_op | input | 3 | Next-counter command: 0 step, 1 short rel, 2 long rel, 3 absolute, 4 restore, 5 hold, 6 high vector, 7 low vector |
| stk_op | input | 2 | Stack command: 0 none, 1 push, 2 pop, 3 none |
| ir_flush | input | 1 | 1 replaces the fetched word with NOP |
| off8 | input | 8 | Signed short branch displacement |
| off11 | input | 11 | Signed long branch displacement |
| abs_target | input | 21 | Absolute jump target |
| prog_data | input | 16 | Program memory word at `prog_addr` |
| prog_addr | output | 21 | Program counter, used as the fetch address |
| instr | output | 16 | Current instruction register |
| stk_err | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The assertions assume that every command code has a defined meaning, so none is illegal. They also assume that `prog_data` is stable while it is sampled. They do not depend on stack depth, so they stay valid even if the decoder combines commands in unusual ways.

The stimulus draws all eight counter codes at random, and it weights push and pop so that the stack moves through its full range without sitting at either end. Directed sequences cover the stack extremes: filling all 16 entries, an overflowing push, a full unwind, and a pop on an empty stack. They also cover the counter wrap at the top of the address space.

// File: rtl/fetch_seq_pkg.sv
// Shared command encodings for the fetch sequencer.
// Assumes a decoder drives these codes directly; every value is defined.
package fetch_seq_pkg;
    typedef enum logic [2:0] {
        PC_STEP  = 3'd0,
        PC_REL_S = 3'd1,
        PC_REL_L = 3'd2,
        PC_JUMP  = 3'd3,
        PC_RESTO = 3'd4,
        PC_HOLD  = 3'd5,
        PC_VEC_H = 3'd6,
        PC_VEC_L = 3'd7
    } pc_cmd_e;

    typedef enum logic [1:0] {
        STK_IDLE = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2,
        STK_RSV  = 2'd3
    } stk_cmd_e;
endpackage

// File: rtl/pc_next_calc.sv
// Combinational next-counter selector.
// Assumes ADDR_W exceeds the long displacement width; wraps modulo 2^ADDR_W.
module pc_next_calc #(
    parameter int ADDR_W = 21,
    parameter int SHORT_W = 8,
    parameter int LONG_W = 11,
    parameter int VEC_HI = 8,
    parameter int VEC_LO = 24
) (
    input  fetch_seq_pkg::pc_cmd_e cmd,
    input  logic [ADDR_W-1:0]      pc_cur,
    input  logic [SHORT_W-1:0]     disp_s,
    input  logic [LONG_W-1:0]      disp_l,
    input  logic [ADDR_W-1:0]      jump_to,
    input  logic [ADDR_W-1:0]      stack_top,
    output logic [ADDR_W-1:0]      pc_nxt
);
    import fetch_seq_pkg::*;

    logic [ADDR_W-1:0] ext_s;
    logic [ADDR_W-1:0] ext_l;

    // Sign-extend both displacements to counter width.
    always_comb begin
        ext_s = {{(ADDR_W-SHORT_W){disp_s[SHORT_W-1]}}, disp_s};
        ext_l = {{(ADDR_W-LONG_W){disp_l[LONG_W-1]}}, disp_l};
    end

    // Pick the next counter value from the command.
    always_comb begin
        unique case (cmd)
            PC_STEP:  pc_nxt = pc_cur + ADDR_W'(1);
            PC_REL_S: pc_nxt = pc_cur + ext_s;
            PC_REL_L: pc_nxt = pc_cur + ext_l;
            PC_JUMP:  pc_nxt = jump_to;
            PC_RESTO: pc_nxt = stack_top;
            PC_HOLD:  pc_nxt = pc_cur;
            PC_VEC_H: pc_nxt = ADDR_W'(VEC_HI);
            PC_VEC_L: pc_nxt = ADDR_W'(VEC_LO);
            default:  pc_nxt = pc_cur;
        endcase
    end
endmodule

// File: rtl/ret_stack.sv
// Return-address stack: pre-increment push, post-decrement pop.
// Assumes one command per cycle; misuse sets a sticky error and changes nothing.
module ret_stack #(
    parameter int ADDR_W = 21,
    parameter int DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  fetch_seq_pkg::stk_cmd_e cmd,
    input  logic [ADDR_W-1:0]      wr_val,
    output logic [ADDR_W-1:0]      top_val,
    output logic                   err
);
    import fetch_seq_pkg::*;

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ADDR_W-1:0] slots [DEPTH];
    logic [CNT_W-1:0]  fill;
    logic              is_full;
    logic              is_empty;
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  rd_idx;

    // Occupancy and slot indices.
    always_comb begin
        is_full  = (fill == CNT_W'(DEPTH));
        is_empty = (fill == '0);
        wr_idx   = IDX_W'(fill);
        rd_idx   = IDX_W'(fill - CNT_W'(1));
        top_val  = is_empty ? '0 : slots[rd_idx];
    end

    // Occupancy counter and sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill <= '0;
            err  <= 1'b0;
        end else begin
            unique case (cmd)
                STK_PUSH: begin
                    if (is_full) err <= 1'b1;
                    else         fill <= fill + CNT_W'(1);
                end
                STK_POP: begin
                    if (is_empty) err <= 1'b1;
                    else          fill <= fill - CNT_W'(1);
                end
                default: ;
            endcase
        end
    end

    // Entry storage, written only on an accepted push.
    always_ff @(posedge clk) begin
        if (cmd == STK_PUSH && !is_full) slots[wr_idx] <= wr_val;
    end
endmodule

// File: rtl/instr_latch.sv
// Instruction register: captures the fetched word or loads an all-zero NOP.
// Assumes the fetched word is valid in the same cycle its address is shown.
module instr_latch #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] word_q
);
    // Capture or cancel the fetched word.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) word_q <= '0;
        else                 word_q <= word_in;
    end
endmodule

// File: rtl/fetch_sequencer.sv
// Top of the fetch sequencer: counter, return stack and instruction register.
// Assumes the decoder gives commands each cycle and memory answers combinationally.
module fetch_sequencer #(
    parameter int ADDR_W = 21,
    parameter int WORD_W = 16,
    parameter int DEPTH = 16,
    parameter int SHORT_W = 8,
    parameter int LONG_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        pc_op,
    input  logic [1:0]        stk_op,
    input  logic              ir_flush,
    input  logic [SHORT_W-1:0] off8,
    input  logic [LONG_W-1:0] off11,
    input  logic [ADDR_W-1:0] abs_target,
    input  logic [WORD_W-1:0] prog_data,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [WORD_W-1:0] instr,
    output logic              stk_err
);
    import fetch_seq_pkg::*;

    pc_cmd_e           pc_cmd;
    stk_cmd_e          stk_cmd;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_d;
    logic [ADDR_W-1:0] tos;

    // Map raw command pins onto typed codes.
    always_comb begin
        pc_cmd  = pc_cmd_e'(pc_op);
        stk_cmd = stk_cmd_e'(stk_op);
    end

    pc_next_calc #(
        .ADDR_W(ADDR_W), .SHORT_W(SHORT_W), .LONG_W(LONG_W),
        .VEC_HI(8), .VEC_LO(24)
    ) nxt_i (
        .cmd(pc_cmd), .pc_cur(pc_q), .disp_s(off8), .disp_l(off11),
        .jump_to(abs_target), .stack_top(tos), .pc_nxt(pc_d)
    );

    ret_stack #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) stk_i (
        .clk(clk), .rst_n(rst_n), .cmd(stk_cmd), .wr_val(pc_q),
        .top_val(tos), .err(stk_err)
    );

    instr_latch #(.WORD_W(WORD_W)) ir_i (
        .clk(clk), .rst_n(rst_n), .flush(ir_flush),
        .word_in(prog_data), .word_q(instr)
    );

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    assign prog_addr = pc_q;
endmodule

// File: rtl/fetch_sequencer_chk.sv
// Property checker for the fetch sequencer, bound to every instance.
// Assumes only port-level visibility; stack depth is not tracked here.
module fetch_sequencer_chk #(
    parameter int ADDR_W = 21,
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        pc_op,
    input logic              ir_flush,
    input logic [ADDR_W-1:0] abs_target,
    input logic [WORD_W-1:0] prog_data,
    input logic [ADDR_W-1:0] prog_addr,
    input logic [WORD_W-1:0] instr,
    input logic              stk_err
);
    p_reset_state_r1: assert property (@(posedge clk)
        (rst_n && $past(!rst_n)) |-> (prog_addr == '0 && instr == '0 && !stk_err));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_op == 3'd0) |=> (prog_addr == $past(prog_addr) + ADDR_W'(1)));

    p_jump_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_op == 3'd3) |=> (prog_addr == $past(abs_target)));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_op == 3'd5) |=> $stable(prog_addr));

    p_vec_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_op == 3'd6) |=> (prog_addr == ADDR_W'(8)));

    p_vec_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_op == 3'd7) |=> (prog_addr == ADDR_W'(24)));

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stk_err |=> stk_err);

    p_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_flush |=> (instr == $past(prog_data)));

    p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ir_flush |=> (instr == '0));
endmodule

bind fetch_sequencer fetch_sequencer_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .pc_op(pc_op), .ir_flush(ir_flush),
    .abs_target(abs_target), .prog_data(prog_data), .prog_addr(prog_addr),
    .instr(instr), .stk_err(stk_err)
);

// File: tb/fetch_sequencer_tb_top.sv
// Self-checking bench: reference model in bench tasks, seeded random plus directed cases.
module fetch_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  pc_op = 3'd0;
    logic [1:0]  stk_op = 2'd0;
    logic        ir_flush = 1'b0;
    logic [7:0]  off8 = '0;
    logic [10:0] off11 = '0;
    logic [20:0] abs_target = '0;
    logic [15:0] prog_data = '0;
    logic [20:0] prog_addr;
    logic [15:0] instr;
    logic        stk_err;

    int checks = 0;
    int failures = 0;

    logic [20:0] m_pc;
    logic [15:0] m_ir;
    logic        m_err;
    logic [20:0] m_stk [16];
    int          m_cnt;
    string       pc_tag;

    always #2.5 clk = ~clk;

    fetch_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .pc_op(pc_op), .stk_op(stk_op),
        .ir_flush(ir_flush), .off8(off8), .off11(off11),
        .abs_target(abs_target), .prog_data(prog_data),
        .prog_addr(prog_addr), .instr(instr), .stk_err(stk_err)
    );

    function automatic logic [15:0] rom_word(input logic [20:0] a);
        return {a[7:0], a[15:8]} ^ 16'hA5C3 ^ {11'd0, a[20:16]};
    endfunction

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0: return "R2";
            3'd1, 3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R6";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic compare_all(input string err_req);
        check(pc_tag, 32'(prog_addr), 32'(m_pc));
        check(ir_flush ? "R10" : "R9", 32'(instr), 32'(m_ir));
        check(err_req, 32'(stk_err), 32'(m_err));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        m_pc = '0; m_ir = '0; m_err = 1'b0; m_cnt = 0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", 32'(prog_addr), 32'd0);
        check("R1", 32'(instr), 32'd0);
        check("R1", 32'(stk_err), 32'd0);
    endtask

    // One cycle: drive commands, advance the model, sample after the edge.
    task automatic cycle(input logic [2:0] pop, input logic [1:0] sop, input logic fl,
                         input logic [7:0] o8, input logic [10:0] o11,
                         input logic [20:0] tgt, input string err_req);
        logic [20:0] tos;
        logic [20:0] nxt;
        pc_op = pop; stk_op = sop; ir_flush = fl;
        off8 = o8; off11 = o11; abs_target = tgt;
        prog_data = rom_word(m_pc);
        tos = (m_cnt == 0) ? 21'd0 : m_stk[m_cnt-1];
        case (pop)
            3'd0: nxt = m_pc + 21'd1;
            3'd1: nxt = m_pc + {{13{o8[7]}}, o8};
            3'd2: nxt = m_pc + {{10{o11[10]}}, o11};
            3'd3: nxt = tgt;
            3'd4: nxt = tos;
            3'd5: nxt = m_pc;
            3'd6: nxt = 21'h08;
            default: nxt = 21'h18;
        endcase
        if (sop == 2'd1) begin
            if (m_cnt == 16) m_err = 1'b1;
            else begin m_stk[m_cnt] = m_pc; m_cnt++; end
        end else if (sop == 2'd2) begin
            if (m_cnt == 0) m_err = 1'b1;
            else m_cnt--;
        end
        m_ir = fl ? 16'd0 : rom_word(m_pc);
        m_pc = nxt;
        pc_tag = tag_of(pop);
        @(negedge clk);
        compare_all(err_req);
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_1234);
        pc_tag = "R1";
        do_reset();

        // R2: wrap at the top of the address space.
        cycle(3'd3, 2'd0, 1'b0, 8'd0, 11'd0, 21'h1FFFFF, "R8");
        cycle(3'd0, 2'd0, 1'b0, 8'd0, 11'd0, 21'd0, "R8");
        check("R2", 32'(prog_addr), 32'd0);
        // R3: negative short and long displacements.
        cycle(3'd3, 2'd0, 1'b0, 8'd0, 11'd0, 21'h100, "R8");
        cycle(3'd1, 2'd0, 1'b0, 8'h80, 11'd0, 21'd0, "R8");
        check("R3", 32'(prog_addr), 32'h80);
        cycle(3'd2, 2'd0, 1'b0, 8'd0, 11'h400, 21'd0, "R8");
        check("R3", 32'(prog_addr), 32'h1FFC80);
        // R10: flush gives NOP.
        cycle(3'd6, 2'd0, 1'b1, 8'd0, 11'd0, 21'd0, "R8");
        check("R10", 32'(instr), 32'd0);
        cycle(3'd7, 2'd0, 1'b0, 8'd0, 11'd0, 21'd0, "R8");

        // R7/R8: fill, overflow, then unwind with restore+pop.
        for (int i = 0; i < 16; i++)
            cycle(3'd3, 2'd1, 1'b0, 8'd0, 11'd0, 21'(32'h1000 + i * 7), "R7");
        cycle(3'd3, 2'd1, 1'b0, 8'd0, 11'd0, 21'h0ABCDE, "R8");
        check("R8", 32'(stk_err), 32'd1);
        for (int i = 0; i < 16; i++)
            cycle(3'd4, 2'd2, 1'b0, 8'd0, 11'd0, 21'd0, "R8");
        do_reset();
        // R8: pop on empty, restore on empty yields 0.
        cycle(3'd3, 2'd0, 1'b0, 8'd0, 11'd0, 21'h33, "R8");
        cycle(3'd4, 2'd2, 1'b0, 8'd0, 11'd0, 21'd0, "R8");
        check("R8", 32'(stk_err), 32'd1);
        cycle(3'd0, 2'd0, 1'b0, 8'd0, 11'd0, 21'd0, "R8");
        check("R8", 32'(stk_err), 32'd1);
        do_reset();

        // Random phase with stack ops biased to move the pointer around.
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] p;
            logic [1:0] s;
            int r;
            p = 3'($urandom_range(0, 7));
            r = $urandom_range(0, 9);
            s = (r < 3) ? 2'd1 : (r < 6) ? 2'd2 : 2'($urandom_range(0, 3));
            if (m_cnt == 0 && s == 2'd2) s = 2'd0;
            if (m_cnt == 16 && s == 2'd1) s = 2'd0;
            cycle(p, s, ($urandom_range(0, 4) == 0), 8'($urandom), 11'($urandom),
                  21'($urandom), "R7");
            if (n % 700 == 699) do_reset();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule